// File: doc/BRIEF.md
# Temperature Code Calibration Converter

This block translates between the raw 8-bit code that an on-die thermal sensor reports and a temperature in whole degrees Celsius. It works in both directions. Code-to-temperature serves readout. Temperature-to-code turns a trip level into the code a comparator would need. Three calibration laws can be selected at run time. The first is a straight line through two trimmed reference points. The second is a single trimmed offset. The third is a fixed default offset taken from a configuration input.

The two reference codes come from a 32-bit trim word, which is captured on a load strobe. A reference that reads as zero, or that falls outside the permitted window, is replaced by the matching byte of a fallback word. Requests use a valid/ready handshake that carries a direction bit and an 8-bit operand. The answer arrives with a one-cycle done pulse, together with an error flag and a signed result. Only one request is handled at a time. The two-point law needs a division, and a sequential shift-subtract divider inside the block performs it.

Top module: `tcc_converter`

## Requirements
- R1: While reset is active and in the first cycle after it, `req_ready` is 1 and `rsp_done`, `rsp_err` and `rsp_value` are 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. After that edge `req_ready` stays 0 until the cycle in which `rsp_done` is 1. `rsp_done` is high for exactly one cycle. With `cal_mode` other than 2'b10, done comes one cycle after the accepting edge. With 2'b10, done comes more than one and at most ARITH_W+3 cycles after that edge.
- R3: With `cal_mode` 2'b00 or 2'b11 (default law), direction 0 (temperature to code) returns operand + `dflt_offset`, and direction 1 (code to temperature) returns operand − `dflt_offset`, as a signed value.
- R4: With `cal_mode` 2'b01 (one-point law), direction 0 returns T + E1 − Tlo and direction 1 returns C − E1 + Tlo, where Tlo is `cal_t_lo`.
- R5: With `cal_mode` 2'b10 (two-point law), direction 0 returns (T − Tlo)·(E2 − E1)/(Thi − Tlo) + E1. The quotient is truncated toward zero.
- R6: With `cal_mode` 2'b10, direction 1 returns (C − E1)·(Thi − Tlo)/(E2 − E1) + Tlo. The quotient is truncated toward zero.
- R7: On `trim_load`, E1 is captured from `trim_word[7:0]`. It is replaced by `fallback_word[7:0]` if it is zero, below `ref_min`, or above `ref_max`. The bounds are inclusive.
- R8: On `trim_load`, E2 is captured from `trim_word[HI_SHIFT+7:HI_SHIFT]` (bits [15:8] by default). If that byte is zero, it is replaced by the same field of `fallback_word`. The other bits of the trim word have no effect.
- R9: When `range_chk_en` is 1, a direction-1 request whose code is below 75 or above 175 returns `rsp_err`=1 and value 0, in every mode. Codes 75 and 175 convert normally. Direction-0 requests are never range checked, and no check is made when `range_chk_en` is 0.
- R10: In the two-point law, a zero divisor (Thi = Tlo for direction 0, E2 = E1 for direction 1) returns `rsp_err`=1 and value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_mode | input | 2 | Calibration law: 00/11 default, 01 one-point, 10 two-point |
| cal_t_lo | input | CODE_W | Lower calibration temperature Tlo |
| cal_t_hi | input | CODE_W | Upper calibration temperature Thi |
| dflt_offset | input | CODE_W | Offset for the default law |
| range_chk_en | input | 1 | Enables the raw-code validity window on readout |
| trim_load | input | 1 | Captures the reference codes from `trim_word` |
| trim_word | input | TRIM_W | Trim word holding E1 and E2 |
| fallback_word | input | TRIM_W | Substitute reference codes |
| ref_min | input | CODE_W | Lowest accepted E1 |
| ref_max | input | CODE_W | Highest accepted E1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_dir | input | 1 | 0 temperature to code, 1 code to temperature |
| req_operand | input | CODE_W | Temperature or code to convert |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_err | output | 1 | Result invalid (range or zero divisor) |
| rsp_value | output | RES_W | Signed result |

## Verification
A wrong captured reference code does not show up as a flag. It shows up only as a shifted result on the next one-point or two-point conversion, one cycle or about twenty cycles after acceptance. The bench therefore reads each substitution case back through a conversion whose result exposes E1 or E2 directly. A divider fault shows up first on a two-point request whose quotient is negative, and only there, because a floor result and a truncated result differ by one only when the quotient is negative. A stuck control state shows up at the ports as `req_ready` staying low, or as a missing or doubled done pulse, within one request.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

   typedef enum logic [1:0] {
      CAL_DFLT   = 2'b00,
      CAL_ONE    = 2'b01,
      CAL_TWO    = 2'b10,
      CAL_DFLT_B = 2'b11
   } cal_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_CALC = 2'b01,
      ST_DIV  = 2'b10
   } conv_state_e;

   localparam logic DIR_T2C = 1'b0;
   localparam logic DIR_C2T = 1'b1;

endpackage

// File: rtl/tcc_trim_resolve.sv
module tcc_trim_resolve #(
   parameter int CODE_W   = 8,
   parameter int TRIM_W   = 32,
   parameter int HI_SHIFT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TRIM_W-1:0] trim_word,
   input  logic [TRIM_W-1:0] fallback_word,
   input  logic [CODE_W-1:0] ref_min,
   input  logic [CODE_W-1:0] ref_max,
   output logic [CODE_W-1:0] ref_lo,
   output logic [CODE_W-1:0] ref_hi
);

   if (HI_SHIFT + CODE_W > TRIM_W) begin : g_bad_shift
      $error("tcc_trim_resolve: high reference field exceeds trim word");
   end
   if (HI_SHIFT < CODE_W) begin : g_bad_overlap
      $error("tcc_trim_resolve: reference fields overlap");
   end

   logic [CODE_W-1:0] raw_lo, raw_hi, fb_lo, fb_hi;
   logic              lo_bad, hi_bad;

   assign raw_lo = trim_word[CODE_W-1:0];
   assign raw_hi = trim_word[HI_SHIFT +: CODE_W];
   assign fb_lo  = fallback_word[CODE_W-1:0];
   assign fb_hi  = fallback_word[HI_SHIFT +: CODE_W];

   assign lo_bad = (raw_lo == '0) || (raw_lo < ref_min) || (raw_lo > ref_max);
   assign hi_bad = (raw_hi == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_lo <= '0;
         ref_hi <= '0;
      end else if (load) begin
         ref_lo <= lo_bad ? fb_lo : raw_lo;
         ref_hi <= hi_bad ? fb_hi : raw_hi;
      end
   end

   // R7: a plausible low reference is taken as is
   a_r7_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (load && raw_lo != '0 && raw_lo >= ref_min && raw_lo <= ref_max)
         |=> ref_lo == $past(raw_lo));

   // R8: a nonzero substitute guarantees a nonzero high reference
   a_r8_hi_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (load && fb_hi != '0) |=> ref_hi != '0);

endmodule

// File: rtl/tcc_sdiv.sv
module tcc_sdiv #(
   parameter int W = 18
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic signed [W-1:0] num,
   input  logic signed [W-1:0] den,
   output logic                busy,
   output logic                done,
   output logic signed [W-1:0] quo
);

   localparam int CNT_W = $clog2(W + 1);

   if (W < 4) begin : g_bad_w
      $error("tcc_sdiv: width too small");
   end

   logic [W:0]       rem, rem_sh, rem_nx;
   logic [W-1:0]     qr, dvs, q_nx, mag_n, mag_d;
   logic             neg, ge;
   logic [CNT_W-1:0] cnt;

   assign mag_n  = num[W-1] ? unsigned'(-num) : unsigned'(num);
   assign mag_d  = den[W-1] ? unsigned'(-den) : unsigned'(den);
   assign rem_sh = {rem[W-1:0], qr[W-1]};
   assign ge     = rem_sh >= {1'b0, dvs};
   assign rem_nx = ge ? rem_sh - {1'b0, dvs} : rem_sh;
   assign q_nx   = {qr[W-2:0], ge};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem  <= '0;
         qr   <= '0;
         dvs  <= '0;
         neg  <= 1'b0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
         quo  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem  <= '0;
            qr   <= mag_n;
            dvs  <= mag_d;
            neg  <= num[W-1] ^ den[W-1];
            cnt  <= CNT_W'(W);
            busy <= 1'b1;
         end else if (busy) begin
            rem <= rem_nx;
            qr  <= q_nx;
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
               quo  <= neg ? -signed'(q_nx) : signed'(q_nx);
            end
         end
      end
   end

   // R5: the final remainder is smaller than the divisor magnitude
   a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rem < {1'b0, dvs});

   // R6: a new division never starts on top of a running one
   a_r6_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/tcc_converter.sv
module tcc_converter
   import tcc_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int TRIM_W      = 32,
   parameter int HI_SHIFT    = 8,
   parameter int ARITH_W     = 18,
   parameter int RES_W       = 16,
   parameter bit RANGE_CHECK = 1'b1,
   parameter int CODE_LO     = 75,
   parameter int CODE_HI     = 175
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              cal_mode,
   input  logic [CODE_W-1:0]       cal_t_lo,
   input  logic [CODE_W-1:0]       cal_t_hi,
   input  logic [CODE_W-1:0]       dflt_offset,
   input  logic                    range_chk_en,
   input  logic                    trim_load,
   input  logic [TRIM_W-1:0]       trim_word,
   input  logic [TRIM_W-1:0]       fallback_word,
   input  logic [CODE_W-1:0]       ref_min,
   input  logic [CODE_W-1:0]       ref_max,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_dir,
   input  logic [CODE_W-1:0]       req_operand,
   output logic                    rsp_done,
   output logic                    rsp_err,
   output logic signed [RES_W-1:0] rsp_value
);

   localparam int PAD_W = ARITH_W - CODE_W;

   if (ARITH_W < 2 * (CODE_W + 1)) begin : g_bad_arith
      $error("tcc_converter: ARITH_W too small for the product");
   end
   if (RES_W > ARITH_W || RES_W < CODE_W + 2) begin : g_bad_res
      $error("tcc_converter: RES_W out of range");
   end
   if (CODE_HI >= (1 << CODE_W) || CODE_LO > CODE_HI) begin : g_bad_window
      $error("tcc_converter: code window out of range");
   end

   function automatic logic signed [ARITH_W-1:0] zx(input logic [CODE_W-1:0] v);
      return $signed({{PAD_W{1'b0}}, v});
   endfunction

   conv_state_e              state;
   cal_mode_e                mode;
   logic [CODE_W-1:0]        op_q, ref_lo, ref_hi;
   logic                     dir_q;
   logic signed [ARITH_W-1:0] op_s, e1_s, e2_s, t1_s, t2_s, off_s;
   logic signed [ARITH_W-1:0] direct_v, num_v, den_v, add_v, add_q, sum_v, div_quo;
   logic                     is_two, range_bad, div_start, div_busy, div_done;

   assign mode      = cal_mode_e'(cal_mode);
   assign req_ready = (state == ST_IDLE);

   tcc_trim_resolve #(
      .CODE_W  (CODE_W),
      .TRIM_W  (TRIM_W),
      .HI_SHIFT(HI_SHIFT)
   ) i_resolve (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (trim_load),
      .trim_word    (trim_word),
      .fallback_word(fallback_word),
      .ref_min      (ref_min),
      .ref_max      (ref_max),
      .ref_lo       (ref_lo),
      .ref_hi       (ref_hi)
   );

   assign op_s  = zx(op_q);
   assign e1_s  = zx(ref_lo);
   assign e2_s  = zx(ref_hi);
   assign t1_s  = zx(cal_t_lo);
   assign t2_s  = zx(cal_t_hi);
   assign off_s = zx(dflt_offset);

   if (RANGE_CHECK) begin : g_range
      assign range_bad = range_chk_en && (dir_q == DIR_C2T) &&
                         ((op_q < CODE_W'(CODE_LO)) || (op_q > CODE_W'(CODE_HI)));
   end else begin : g_no_range
      logic unused_range_en;
      assign unused_range_en = range_chk_en;
      assign range_bad       = 1'b0;
   end

   always_comb begin
      is_two   = 1'b0;
      direct_v = '0;
      case (mode)
         CAL_ONE: direct_v = (dir_q == DIR_C2T) ? op_s - e1_s + t1_s
                                                : op_s + e1_s - t1_s;
         CAL_TWO: is_two   = 1'b1;
         default: direct_v = (dir_q == DIR_C2T) ? op_s - off_s : op_s + off_s;
      endcase
   end

   always_comb begin
      if (dir_q == DIR_C2T) begin
         num_v = (op_s - e1_s) * (t2_s - t1_s);
         den_v = e2_s - e1_s;
         add_v = t1_s;
      end else begin
         num_v = (op_s - t1_s) * (e2_s - e1_s);
         den_v = t2_s - t1_s;
         add_v = e1_s;
      end
   end

   assign div_start = (state == ST_CALC) && !range_bad && is_two && (den_v != '0);
   assign sum_v     = div_quo + add_q;

   tcc_sdiv #(
      .W(ARITH_W)
   ) i_div (
      .clk  (clk),
      .rst_n(rst_n),
      .start(div_start),
      .num  (num_v),
      .den  (den_v),
      .busy (div_busy),
      .done (div_done),
      .quo  (div_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op_q      <= '0;
         dir_q     <= 1'b0;
         add_q     <= '0;
         rsp_done  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_value <= '0;
      end else begin
         rsp_done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  op_q  <= req_operand;
                  dir_q <= req_dir;
                  state <= ST_CALC;
               end
            end
            ST_CALC: begin
               if (range_bad || (is_two && den_v == '0)) begin
                  rsp_done  <= 1'b1;
                  rsp_err   <= 1'b1;
                  rsp_value <= '0;
                  state     <= ST_IDLE;
               end else if (is_two) begin
                  add_q <= add_v;
                  state <= ST_DIV;
               end else begin
                  rsp_done  <= 1'b1;
                  rsp_err   <= 1'b0;
                  rsp_value <= direct_v[RES_W-1:0];
                  state     <= ST_IDLE;
               end
            end
            ST_DIV: begin
               if (div_done) begin
                  rsp_done  <= 1'b1;
                  rsp_err   <= 1'b0;
                  rsp_value <= sum_v[RES_W-1:0];
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: acceptance closes the handshake for the next cycle
   a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2: done is a single-cycle strobe
   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R2: a result only follows a busy cycle
   a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $past(!req_ready));

   // R10: an error result carries a zero value
   a_r10_err_value_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_err) |-> rsp_value == '0);

   // R5: the divider only reports while a two-point request waits on it
   a_r5_div_done_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |-> (state == ST_DIV && !div_busy));

endmodule

// File: tb/test_tcc_converter.sv
module test_tcc_converter;

   localparam int CLK_P = 10;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        cal_mode;
   logic [7:0]        cal_t_lo, cal_t_hi, dflt_offset, ref_min, ref_max, req_operand;
   logic              range_chk_en, trim_load, req_valid, req_dir;
   logic [31:0]       trim_word, fallback_word;
   logic              req_ready, rsp_done, rsp_err;
   logic signed [15:0] rsp_value;

   int n_chk = 0;
   int n_bad = 0;
   int e1m, e2m;

   always #(CLK_P / 2) clk = ~clk;

   tcc_converter i_tcc_converter (
      .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .cal_t_lo(cal_t_lo),
      .cal_t_hi(cal_t_hi), .dflt_offset(dflt_offset), .range_chk_en(range_chk_en),
      .trim_load(trim_load), .trim_word(trim_word), .fallback_word(fallback_word),
      .ref_min(ref_min), .ref_max(ref_max), .req_valid(req_valid),
      .req_ready(req_ready), .req_dir(req_dir), .req_operand(req_operand),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_value(rsp_value)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic void model(input logic d, input int op, output int v, output bit e);
      int den, num;
      e = 1'b0;
      v = 0;
      if (range_chk_en && d && (op < 75 || op > 175)) begin
         e = 1'b1;
         return;
      end
      case (cal_mode)
         2'b01: v = d ? op - e1m + int'(cal_t_lo) : op + e1m - int'(cal_t_lo);
         2'b10: begin
            den = d ? e2m - e1m : int'(cal_t_hi) - int'(cal_t_lo);
            if (den == 0) begin
               e = 1'b1;
               return;
            end
            num = d ? (op - e1m) * (int'(cal_t_hi) - int'(cal_t_lo))
                    : (op - int'(cal_t_lo)) * (e2m - e1m);
            v = num / den + (d ? int'(cal_t_lo) : e1m);
         end
         default: v = d ? op - int'(dflt_offset) : op + int'(dflt_offset);
      endcase
   endfunction

   task automatic conv(input logic d, input logic [7:0] op, output int v, output bit e,
                       output int lat, output bit busy_ok);
      @(negedge clk);
      req_dir = d; req_operand = op; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 0;
      busy_ok = 1'b1;
      while (!rsp_done && lat < 64) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      v = int'(rsp_value);
      e = rsp_err;
   endtask

   task automatic check_conv(input string req, input logic d, input logic [7:0] op);
      int v, lat, ev;
      bit e, ee, bo;
      conv(d, op, v, e, lat, bo);
      model(d, int'(op), ev, ee);
      chk({req, " value"}, v, ev);
      chk({req, " err"}, int'(e), int'(ee));
   endtask

   task automatic load_trim(input logic [31:0] w, input int exp_e1, input int exp_e2);
      @(negedge clk);
      trim_word = w; trim_load = 1'b1;
      @(negedge clk);
      trim_load = 1'b0;
      e1m = exp_e1;
      e2m = exp_e2;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 ready in reset", int'(req_ready), 1);
      chk("R1 outputs in reset", int'({rsp_done, rsp_err}) + int'(rsp_value), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", int'(req_ready), 1);
      chk("R1 value after reset", int'(rsp_value), 0);
   endtask

   task automatic t_default;
      cal_mode = 2'b00; dflt_offset = 8'd50; range_chk_en = 1'b0;
      check_conv("R3 t2c", 1'b0, 8'd30);
      check_conv("R3 c2t negative", 1'b1, 8'd20);
      cal_mode = 2'b11;
      check_conv("R3 alt encoding c2t", 1'b1, 8'd200);
      check_conv("R3 alt encoding t2c", 1'b0, 8'd0);
   endtask

   task automatic t_one_point;
      cal_mode = 2'b01; cal_t_lo = 8'd25; cal_t_hi = 8'd85;
      load_trim(32'h0000_7032, 50, 112);
      check_conv("R4 t2c", 1'b0, 8'd30);
      check_conv("R4 c2t", 1'b1, 8'd100);
      check_conv("R4 c2t below ref", 1'b1, 8'd10);
   endtask

   task automatic t_two_point;
      cal_mode = 2'b10;
      check_conv("R5 exact", 1'b0, 8'd85);
      check_conv("R5 small step", 1'b0, 8'd26);
      check_conv("R5 negative truncation", 1'b0, 8'd20);
      check_conv("R5 zero temp", 1'b0, 8'd0);
      check_conv("R5 high temp", 1'b0, 8'd200);
      check_conv("R6 negative truncation", 1'b1, 8'd40);
      check_conv("R6 at high ref", 1'b1, 8'd112);
      check_conv("R6 high code", 1'b1, 8'd200);
   endtask

   task automatic t_fallback_lo;
      cal_mode = 2'b01; cal_t_lo = 8'd25;
      load_trim(32'h0000_7000, 60, 112);
      check_conv("R7 zero replaced", 1'b1, 8'd100);
      load_trim(32'h0000_7005, 60, 112);
      check_conv("R7 below min replaced", 1'b1, 8'd100);
      load_trim(32'h0000_7090, 60, 112);
      check_conv("R7 above max replaced", 1'b1, 8'd100);
      load_trim(32'h0000_7010, 16, 112);
      check_conv("R7 min kept", 1'b1, 8'd100);
      load_trim(32'h0000_7060, 96, 112);
      check_conv("R7 max kept", 1'b1, 8'd100);
      load_trim(32'h0000_7061, 60, 112);
      check_conv("R7 max plus one replaced", 1'b1, 8'd100);
   endtask

   task automatic t_fallback_hi;
      cal_mode = 2'b10; cal_t_lo = 8'd25; cal_t_hi = 8'd85;
      load_trim(32'h0000_0032, 50, 90);
      check_conv("R8 zero replaced", 1'b0, 8'd85);
      load_trim(32'hFFAB_3432, 50, 52);
      check_conv("R8 field kept upper bits ignored", 1'b0, 8'd85);
      check_conv("R8 c2t", 1'b1, 8'd51);
   endtask

   task automatic t_range;
      cal_mode = 2'b00; dflt_offset = 8'd50; range_chk_en = 1'b1;
      check_conv("R9 below window", 1'b1, 8'd74);
      check_conv("R9 low edge", 1'b1, 8'd75);
      check_conv("R9 high edge", 1'b1, 8'd175);
      check_conv("R9 above window", 1'b1, 8'd176);
      check_conv("R9 zero code", 1'b1, 8'd0);
      check_conv("R9 t2c unchecked", 1'b0, 8'd10);
      cal_mode = 2'b10;
      check_conv("R9 two-point checked", 1'b1, 8'd200);
      range_chk_en = 1'b0; cal_mode = 2'b00;
      check_conv("R9 disabled", 1'b1, 8'd74);
   endtask

   task automatic t_zero_div;
      cal_mode = 2'b10; cal_t_lo = 8'd40; cal_t_hi = 8'd40;
      load_trim(32'h0000_7032, 50, 112);
      check_conv("R10 equal temps t2c", 1'b0, 8'd60);
      check_conv("R10 equal temps c2t ok", 1'b1, 8'd60);
      cal_t_lo = 8'd25; cal_t_hi = 8'd85;
      load_trim(32'h0000_3232, 50, 50);
      check_conv("R10 equal refs c2t", 1'b1, 8'd80);
      check_conv("R10 equal refs t2c ok", 1'b0, 8'd80);
   endtask

   task automatic t_handshake;
      int v, lat;
      bit e, bo;
      load_trim(32'h0000_7032, 50, 112);
      cal_mode = 2'b01;
      conv(1'b0, 8'd30, v, e, lat, bo);
      chk("R2 direct latency", lat, 1);
      chk("R2 ready back with done", int'(req_ready), 1);
      @(negedge clk);
      chk("R2 done single cycle", int'(rsp_done), 0);
      cal_mode = 2'b10;
      conv(1'b0, 8'd20, v, e, lat, bo);
      chk("R2 ready low while dividing", int'(bo), 1);
      chk("R2 divide latency bounded", int'(lat > 1 && lat <= 21), 1);
      @(negedge clk);
      chk("R2 divide done single cycle", int'(rsp_done), 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      cal_mode = 2'b00; cal_t_lo = 8'd25; cal_t_hi = 8'd85; dflt_offset = 8'd50;
      range_chk_en = 1'b0; trim_load = 1'b0; trim_word = '0;
      fallback_word = 32'h0000_5A3C; ref_min = 8'd16; ref_max = 8'd96;
      req_valid = 1'b0; req_dir = 1'b0; req_operand = '0;
      e1m = 0; e2m = 0;
      t_reset;
      t_default;
      t_one_point;
      t_two_point;
      t_fallback_lo;
      t_fallback_hi;
      t_range;
      t_zero_div;
      t_handshake;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule